// File: doc/BRIEF.md
# Listener Byte Acceptor for a Three-Wire Instrument Bus

This block is the receive side of a byte-serial, three-wire interlocked parallel bus. Toward the bus it monitors the data-valid line, the attention line, the interface-clear line and the data lines, all of which are low-true at its pins. It produces two high-true hold-off outputs, ready-for-data and data-accepted. External inverting drivers turn these into the open-collector not-ready and not-accepted lines. Every bus input is sampled on the falling clock edge. Every state change happens on the rising edge.

Toward the instrument, each captured byte is offered as a stream item. `byte_vld` presents the byte. The instrument answers on `dev_busy`. Back-pressure follows three rules:
- While `byte_vld` is high, `byte_data` and `byte_cmd` are held stable.
- The item counts as taken once `dev_busy` is seen high during the offer.
- A new byte is invited on the bus only after `dev_busy` is seen low again.

An instrument that can take a byte within one clock of `byte_vld` rising may tie `byte_vld` straight to `dev_busy`. The byte the talker places on the bus has to settle before data-valid is asserted. A parameterised data-delay phase adds further settling margin before the byte is offered.

Top module: `lsn_accept_hs`

## Requirements
- R1: While `pwr_rst` is high, the block is idle: `bus_rfd`=1, `bus_dac`=1 (both bus lines released) and `byte_vld`=0.
- R2: The acceptor is active only while `listen_en`=1 or attention is true (`bus_atn_n`=0). One cycle after it is seen inactive, the block is idle as in R1. A data-valid strobe received while it is inactive produces no byte.
- R3: Once active, the block first enters not-ready (`bus_rfd`=0, `bus_dac`=0). It raises `bus_rfd` one cycle after it sees `dev_busy`=0 with data-valid false. While `dev_busy`=1 it stays not-ready.
- R4: While active, `bus_rfd`=1 only in the ready phase, and `bus_rfd` and `bus_dac` are never both 1.
- R5: In the ready phase, a low `bus_dav_n` drops `bus_rfd` on the next rising edge. At that same edge the block captures `~bus_dio_n` into `byte_data` and the attention state (1 = true) into `byte_cmd`.
- R6: With `DELAY_CYC`=1, `byte_vld` rises one cycle after capture. While it is high, `byte_data` and `byte_cmd` stay stable.
- R7: `byte_vld` stays high until `dev_busy`=1 is seen. One cycle later `byte_vld`=0 and `bus_dac`=1.
- R8: `bus_dac` stays 1 while data-valid stays true. One cycle after data-valid is seen false, `bus_dac`=0 and the block is not-ready again.
- R9: Interface clear true (`bus_ifc_n`=0) puts the block in the idle state of R1 one cycle after it is seen, from any phase.
- R10: With `byte_vld` tied to `dev_busy`, every byte handed over by a talker is delivered once, in order, with its command flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on falling edge, state on rising edge |
| pwr_rst | input | 1 | High-true power-on reset to the idle state |
| listen_en | input | 1 | Device is addressed to listen (or listen-only) |
| bus_atn_n | input | 1 | Attention line, low-true |
| bus_ifc_n | input | 1 | Interface clear line, low-true |
| bus_dav_n | input | 1 | Data valid line, low-true |
| bus_dio_n | input | DATA_W | Data lines, low-true |
| dev_busy | input | 1 | Instrument not ready for the next byte |
| bus_rfd | output | 1 | Ready for data, high-true (inverted by external driver) |
| bus_dac | output | 1 | Data accepted, high-true (inverted by external driver) |
| byte_vld | output | 1 | Captured byte offered to the instrument |
| byte_data | output | DATA_W | Captured byte, true polarity |
| byte_cmd | output | 1 | Byte was received with attention true |

## Verification
Any input change driven between rising edges reaches a falling-edge sample and acts at the next rising edge. Each result is therefore due a fixed number of edges after its stimulus:
- `bus_rfd` falls, and the byte is captured, one edge after data-valid.
- `byte_vld` rises two edges after data-valid.
- `bus_dac` rises one edge after busy is seen.
- The idle state follows interface clear or deactivation by one edge.

The bench drives inputs just after a rising edge and reads the outputs a few nanoseconds after the counted edge. Each protocol step is checked on exactly the edge it is due. A scoreboard pops each expected byte at the rising edge of `byte_vld`.

// File: rtl/lsn_accept_pkg.sv
package lsn_accept_pkg;

  // Acceptor phases
  typedef enum logic [2:0] {
    ST_IDLE,   // inactive, bus lines released
    ST_NRDY,   // holding off the talker
    ST_RDY,    // inviting a byte
    ST_DLY,    // byte latched, settling
    ST_OFFER,  // byte offered to instrument
    ST_ACPT    // accepted, waiting for data-valid to drop
  } acc_state_e;

  // Bit positions in the synchronised control vector
  localparam int unsigned SY_BUSY = 0;
  localparam int unsigned SY_DAV  = 1;
  localparam int unsigned SY_IFC  = 2;
  localparam int unsigned SY_ATN  = 3;
  localparam int unsigned SY_LSN  = 4;
  localparam int unsigned SY_CTRL_W = 5;

  function automatic logic rfd_of(acc_state_e s);
    return (s == ST_IDLE) || (s == ST_RDY);
  endfunction

  function automatic logic dac_of(acc_state_e s);
    return (s == ST_IDLE) || (s == ST_ACPT);
  endfunction

  function automatic logic vld_of(acc_state_e s);
    return (s == ST_OFFER);
  endfunction

endpackage

// File: rtl/lsn_bus_sync.sv
module lsn_bus_sync #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  // Falling-edge sampling chain; the rising-edge logic sees the last stage
  always_ff @(negedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/lsn_byte_latch.sv
module lsn_byte_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] din,
  input  logic              cmd_in,
  output logic [DATA_W-1:0] dout,
  output logic              cmd_out
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dout    <= '0;
      cmd_out <= 1'b0;
    end else if (cap_en) begin
      dout    <= din;
      cmd_out <= cmd_in;
    end
  end

endmodule

// File: rtl/lsn_accept_fsm.sv
module lsn_accept_fsm
  import lsn_accept_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic active_s,
  input  logic ifc_s,
  input  logic dav_s,
  input  logic busy_s,
  output logic rfd,
  output logic dac,
  output logic vld,
  output logic cap_en
);

  localparam int unsigned CW = $clog2(DELAY_CYC + 1);

  acc_state_e     st, nxt;
  logic [CW-1:0]  dly_cnt;
  logic           go;

  assign go = active_s && !ifc_s;

  always_comb begin
    nxt = st;
    if (!go) begin
      nxt = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:  nxt = ST_NRDY;
        ST_NRDY:  if (!busy_s && !dav_s) nxt = ST_RDY;
        ST_RDY: begin
          if (dav_s)       nxt = ST_DLY;
          else if (busy_s) nxt = ST_NRDY;
        end
        ST_DLY:   if (dly_cnt == CW'(DELAY_CYC - 1)) nxt = ST_OFFER;
        ST_OFFER: if (busy_s) nxt = ST_ACPT;
        ST_ACPT:  if (!dav_s) nxt = ST_NRDY;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)               dly_cnt <= '0;
    else if (st != ST_DLY) dly_cnt <= '0;
    else                   dly_cnt <= dly_cnt + 1'b1;
  end

  assign rfd    = rfd_of(st);
  assign dac    = dac_of(st);
  assign vld    = vld_of(st);
  assign cap_en = go && (st == ST_RDY) && dav_s;

  // R2: inactive means idle on the next edge
  a_r2_idle_when_inactive: assert property (@(posedge clk) disable iff (rst)
    !active_s |=> (rfd && dac && !vld));

  // R3: no invitation while the instrument is busy
  a_r3_no_rfd_when_busy: assert property (@(posedge clk) disable iff (rst)
    (go && st == ST_NRDY && busy_s) |=> !rfd);

  // R4: never invite and accept at once while active
  a_r4_rfd_dac_excl: assert property (@(posedge clk) disable iff (rst)
    (go && st != ST_IDLE) |-> !(rfd && dac));

  // R5: data-valid in ready phase withdraws ready-for-data
  a_r5_rfd_falls: assert property (@(posedge clk) disable iff (rst)
    (go && rfd && st == ST_RDY && dav_s) |=> !rfd);

  // R7: busy seen during the offer releases data-accepted
  a_r7_take_releases_dac: assert property (@(posedge clk) disable iff (rst)
    (go && vld && busy_s) |=> (!vld && dac));

  // R8: data-accepted held while data-valid stays true
  a_r8_dac_held: assert property (@(posedge clk) disable iff (rst)
    (go && st == ST_ACPT && dav_s) |=> dac);

  // R9: interface clear forces idle
  a_r9_ifc_idle: assert property (@(posedge clk) disable iff (rst)
    ifc_s |=> (rfd && dac && !vld));

endmodule

// File: rtl/lsn_accept_hs.sv
module lsn_accept_hs
  import lsn_accept_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SYNC_DEPTH = 1,
  parameter int unsigned DELAY_CYC  = 1
) (
  input  logic              clk,
  input  logic              pwr_rst,
  input  logic              listen_en,
  input  logic              bus_atn_n,
  input  logic              bus_ifc_n,
  input  logic              bus_dav_n,
  input  logic [DATA_W-1:0] bus_dio_n,
  input  logic              dev_busy,
  output logic              bus_rfd,
  output logic              bus_dac,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_cmd
);

  localparam int unsigned SW = DATA_W + SY_CTRL_W;

  logic [SW-1:0] sy_d, sy_q;
  logic          cap_en;
  logic          active_s;

  // Bus lines are low-true; convert to true polarity before sampling
  always_comb begin
    sy_d = '0;
    sy_d[SY_BUSY] = dev_busy;
    sy_d[SY_DAV]  = ~bus_dav_n;
    sy_d[SY_IFC]  = ~bus_ifc_n;
    sy_d[SY_ATN]  = ~bus_atn_n;
    sy_d[SY_LSN]  = listen_en;
    sy_d[SW-1:SY_CTRL_W] = ~bus_dio_n;
  end

  lsn_bus_sync #(.W(SW), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (pwr_rst),
    .d   (sy_d),
    .q   (sy_q)
  );

  assign active_s = sy_q[SY_LSN] || sy_q[SY_ATN];

  lsn_accept_fsm #(.DELAY_CYC(DELAY_CYC)) u_fsm (
    .clk      (clk),
    .rst      (pwr_rst),
    .active_s (active_s),
    .ifc_s    (sy_q[SY_IFC]),
    .dav_s    (sy_q[SY_DAV]),
    .busy_s   (sy_q[SY_BUSY]),
    .rfd      (bus_rfd),
    .dac      (bus_dac),
    .vld      (byte_vld),
    .cap_en   (cap_en)
  );

  lsn_byte_latch #(.DATA_W(DATA_W)) u_latch (
    .clk     (clk),
    .rst     (pwr_rst),
    .cap_en  (cap_en),
    .din     (sy_q[SW-1:SY_CTRL_W]),
    .cmd_in  (sy_q[SY_ATN]),
    .dout    (byte_data),
    .cmd_out (byte_cmd)
  );

  // R1: reset holds the idle state
  a_r1_reset_idle: assert property (@(posedge clk)
    pwr_rst |-> (bus_rfd && bus_dac && !byte_vld));

  // R6: offered byte does not move
  a_r6_offer_stable: assert property (@(posedge clk) disable iff (pwr_rst)
    (byte_vld && $past(byte_vld)) |-> ($stable(byte_data) && $stable(byte_cmd)));

endmodule

// File: tb/lsn_accept_hs_tb_top.sv
module lsn_accept_hs_tb_top;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          pwr_rst;
  logic          listen_en;
  logic          bus_atn_n, bus_ifc_n, bus_dav_n;
  logic [DW-1:0] bus_dio_n;
  logic          dev_busy;
  logic          bus_rfd, bus_dac, byte_vld, byte_cmd;
  logic [DW-1:0] byte_data;

  logic tie_mode;
  logic slow_busy;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [DW:0] exp_q[$];
  logic        prev_vld = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  assign dev_busy = tie_mode ? byte_vld : slow_busy;

  lsn_accept_hs #(.DATA_W(DW)) dut_i (
    .clk       (clk),
    .pwr_rst   (pwr_rst),
    .listen_en (listen_en),
    .bus_atn_n (bus_atn_n),
    .bus_ifc_n (bus_ifc_n),
    .bus_dav_n (bus_dav_n),
    .bus_dio_n (bus_dio_n),
    .dev_busy  (dev_busy),
    .bus_rfd   (bus_rfd),
    .bus_dac   (bus_dac),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .byte_cmd  (byte_cmd)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #4;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Scoreboard monitor: each offered byte must match the queue head (R10)
  always @(posedge clk) begin
    #3;
    if (!pwr_rst && byte_vld && !prev_vld) begin
      if (exp_q.size() == 0) begin
        chk("R10", "unexpected byte", 32'({byte_cmd, byte_data}), 32'h1ff);
      end else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        chk("R10", "delivered byte", 32'({byte_cmd, byte_data}), 32'(e));
      end
    end
    prev_vld = byte_vld;
  end

  // Talker model: full interlocked handshake for one byte
  task automatic send_byte(input logic [DW-1:0] d, input logic cmd);
    int n;
    bus_atn_n = !cmd;
    n = 0;
    while (!bus_rfd && n < 40) begin tick(); n++; end
    chk("R3", "ready before send", 32'(bus_rfd), 32'h1);
    bus_dio_n = ~d;
    bus_dav_n = 1'b0;
    exp_q.push_back({cmd, d});
    n = 0;
    do begin
      tick(); n++;
      if (bus_rfd && bus_dac) chk("R4", "rfd and dac both high", 32'h1, 32'h0);
    end while (!bus_dac && n < 40);
    chk("R7", "data accepted reached", 32'(bus_dac), 32'h1);
    bus_dav_n = 1'b1;
    tick();
    chk("R8", "dac drops after dav false", 32'(bus_dac), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    pwr_rst = 1'b1; listen_en = 1'b0; bus_atn_n = 1'b1; bus_ifc_n = 1'b1;
    bus_dav_n = 1'b1; bus_dio_n = '1; tie_mode = 1'b1; slow_busy = 1'b0;
    repeat (3) tick();
    // R1 reset state
    chk("R1", "rfd in reset", 32'(bus_rfd), 32'h1);
    chk("R1", "dac in reset", 32'(bus_dac), 32'h1);
    chk("R1", "vld in reset", 32'(byte_vld), 32'h0);
    pwr_rst = 1'b0;
    tick(); tick();

    // R2 inactive: strobe ignored
    bus_dio_n = ~8'h77; bus_dav_n = 1'b0;
    tick(); tick(); tick();
    chk("R2", "vld while inactive", 32'(byte_vld), 32'h0);
    chk("R2", "rfd while inactive", 32'(bus_rfd), 32'h1);
    chk("R2", "dac while inactive", 32'(bus_dac), 32'h1);
    bus_dav_n = 1'b1;
    tick();

    // R3 activation
    listen_en = 1'b1;
    tick();
    chk("R3", "not-ready rfd", 32'(bus_rfd), 32'h0);
    chk("R3", "not-ready dac", 32'(bus_dac), 32'h0);
    tick();
    chk("R3", "ready rfd", 32'(bus_rfd), 32'h1);

    // R5..R8 exact timing, tied instrument
    bus_dio_n = ~8'h3c; bus_dav_n = 1'b0; exp_q.push_back({1'b0, 8'h3c});
    tick();
    chk("R5", "rfd falls", 32'(bus_rfd), 32'h0);
    chk("R5", "captured data", 32'(byte_data), 32'h3c);
    chk("R5", "no offer yet", 32'(byte_vld), 32'h0);
    tick();
    chk("R6", "offer raised", 32'(byte_vld), 32'h1);
    tick();
    chk("R7", "offer dropped", 32'(byte_vld), 32'h0);
    chk("R7", "dac raised", 32'(bus_dac), 32'h1);
    tick(); tick();
    chk("R8", "dac held", 32'(bus_dac), 32'h1);
    bus_dav_n = 1'b1;
    tick();
    chk("R8", "dac released", 32'(bus_dac), 32'h0);
    chk("R8", "not ready again", 32'(bus_rfd), 32'h0);
    tick();
    chk("R3", "ready again", 32'(bus_rfd), 32'h1);

    // R6/R7 slow instrument
    tie_mode = 1'b0; slow_busy = 1'b0;
    bus_dio_n = ~8'hc5; bus_dav_n = 1'b0; exp_q.push_back({1'b0, 8'hc5});
    tick(); tick();
    chk("R6", "slow offer raised", 32'(byte_vld), 32'h1);
    bus_dio_n = ~8'h00;
    tick(); tick(); tick();
    chk("R7", "offer held while not busy", 32'(byte_vld), 32'h1);
    chk("R7", "dac low while offering", 32'(bus_dac), 32'h0);
    chk("R6", "data stable", 32'(byte_data), 32'hc5);
    slow_busy = 1'b1;
    tick();
    chk("R7", "slow take", 32'({byte_vld, bus_dac}), 32'h1);
    bus_dav_n = 1'b1;
    tick(); tick(); tick();
    chk("R3", "held off while busy", 32'(bus_rfd), 32'h0);
    slow_busy = 1'b0;
    tick();
    chk("R3", "ready after busy clears", 32'(bus_rfd), 32'h1);

    // R9 interface clear during accept
    tie_mode = 1'b1;
    bus_dio_n = ~8'h81; bus_dav_n = 1'b0; exp_q.push_back({1'b0, 8'h81});
    tick(); tick(); tick();
    chk("R9", "in accept", 32'(bus_dac), 32'h1);
    bus_ifc_n = 1'b0;
    tick();
    chk("R9", "idle after clear", 32'({bus_rfd, bus_dac, byte_vld}), 32'h6);
    tick();
    chk("R9", "idle held", 32'({bus_rfd, bus_dac, byte_vld}), 32'h6);
    bus_ifc_n = 1'b1; bus_dav_n = 1'b1;
    tick();
    chk("R9", "not ready after clear", 32'(bus_rfd), 32'h0);
    tick();

    // R2 deactivation during an offer
    tie_mode = 1'b0; slow_busy = 1'b0;
    bus_dio_n = ~8'h42; bus_dav_n = 1'b0; exp_q.push_back({1'b0, 8'h42});
    tick(); tick();
    chk("R2", "offer before deactivation", 32'(byte_vld), 32'h1);
    listen_en = 1'b0;
    tick();
    chk("R2", "idle after deactivation", 32'({bus_rfd, bus_dac, byte_vld}), 32'h6);
    bus_dav_n = 1'b1;
    tick();

    // R2 attention alone activates; command flag captured (R5)
    tie_mode = 1'b1;
    bus_atn_n = 1'b0;
    tick(); tick();
    send_byte(8'h5a, 1'b1);
    chk("R5", "command flag", 32'(byte_cmd), 32'h1);
    bus_atn_n = 1'b1;
    tick(); tick();

    // R10 burst, tied instrument, mixed command flags
    listen_en = 1'b1;
    tick(); tick();
    for (int i = 0; i < 12; i++) begin
      send_byte(8'((i * 37 + 1) & 8'hff), 1'((i % 3) == 0));
    end
    tick(); tick();
    chk("R10", "queue drained", 32'(exp_q.size()), 32'h0);

    finish_run();
  end

endmodule